// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. A five-bit command picks one of eight analog inputs, says whether conversion should begin at once or wait for a trigger pulse from an output-event unit, and picks an 8-bit or 10-bit result. The sequencer then drives the channel select, holds the sample-and-hold enable open for the sampling window, and steps a trial code into the DAC one bit at a time from the MSB down. At the end of each bit period it strobes the comparator. The analog multiplexer, DAC and comparator sit outside the block. Only the single comparator bit comes back in.

Timing is counted in state times, where one state time is one clock cycle. Two fixed profiles are available. The normal profile samples for 15 and converts for 158 in total. The fast profile samples for 8 and converts for 91 in total. A configuration input replaces both profiles with a programmed sample count and a programmed conversion count. The time left after sampling is shared out evenly over the bit decisions, and any remainder goes to the final bit. When the last bit is decided the block loads the result register, drops busy and raises a pending flag. The pending flag reaches the interrupt output only through a mask.

Top module: `adc_sar_seq`

## Requirements
- R1: When a command is accepted, command bits [2:0] are latched and drive `chanSel` from the following cycle until the next accepted command.
- R2: A command accepted with bit 3 set starts sampling at once: `busy` and `sampleEn` are high in the cycle after the write.
- R3: A command accepted with bit 3 clear arms the block without starting it. `busy` goes high in the cycle after an `extTrig` pulse. An `extTrig` pulse while the block is idle and not armed has no effect.
- R4: Command bit 4 set gives an 8-bit conversion: only result bits [9:2] are decided and `result[1:0]` reads 0. Bit 4 clear gives a 10-bit conversion.
- R5: With `cfgTiming` low and `fastMode` low, `sampleEn` is high for 15 cycles and `busy` for 158 cycles.
- R6: With `cfgTiming` low and `fastMode` high, `sampleEn` is high for 8 cycles and `busy` for 91 cycles.
- R7: With `cfgTiming` high, `sampleEn` is high for `sampleCnt` cycles and `busy` for `sampleCnt + convertCnt` cycles, whatever `fastMode` is (this assumes `sampleCnt` ≥ 1 and `convertCnt` ≥ the bit count).
- R8: Each bit period lasts floor((total − sample) / N) cycles, where N is 8 or 10, and the last bit period also gets the remainder. `compStrobe` is high for one cycle at the end of each bit period, so it fires N times in all.
- R9: Approximation runs from the MSB down. During each bit period `dacCode` shows the bits kept so far plus the bit under trial. The trial bit is kept only if `compIn` is 1 (input at or above the trial level) when `compStrobe` is high.
- R10: `busy` stays high from the first sampling cycle to the last bit decision. A command written while `busy` is high is ignored.
- R11: `donePend` rises in the same cycle that `busy` falls, together with the new `result`, and stays set until `pendAck`. `intOut` is `donePend` AND `intMask`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one state time per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWr | input | 1 | Command write strobe |
| cmdData | input | 5 | Command: [2:0] channel, [3] start at once, [4] 8-bit |
| extTrig | input | 1 | Start pulse from the output-event unit |
| fastMode | input | 1 | Fixed profile select: 1 fast, 0 normal |
| cfgTiming | input | 1 | 1 uses the programmed counts instead of the fixed profiles |
| sampleCnt | input | 6 | Programmed sample length in cycles |
| convertCnt | input | 10 | Programmed post-sample conversion length in cycles |
| compIn | input | 1 | Comparator result, 1 when input ≥ DAC level |
| intMask | input | 1 | Interrupt enable for conversion complete |
| pendAck | input | 1 | Clears the pending flag |
| chanSel | output | 3 | Analog channel select |
| sampleEn | output | 1 | Sample-and-hold enable |
| dacCode | output | 10 | Trial code to the DAC |
| compStrobe | output | 1 | Comparator decision strobe |
| result | output | 10 | Last conversion result |
| busy | output | 1 | Conversion in progress |
| donePend | output | 1 | Conversion-complete pending flag |
| intOut | output | 1 | Masked conversion-complete interrupt |

## Verification
`busy`, `sampleEn` and `chanSel` are due one cycle after the write or trigger edge. `result` and `donePend` are due in the first cycle with `busy` low, which is the total conversion length plus one after the start edge. Each `compStrobe` falls at a cycle offset that follows from the sample length and the bit-period split. The bench drives inputs on the falling edge and samples on the next falling edge. It numbers each cycle from the start edge, so the sample length, busy length, first strobe position, last strobe gap and result are each compared in the exact cycle the requirements give.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SAMPLE,
    ST_CONVERT
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // latch channel and width from the command
    logic startBits;  // clear approximation, place trial bit at MSB
    logic decide;     // apply comparator to current trial bit
    logic finish;     // last decision: copy code into result
  } dpStrobe_t;

endpackage

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
  import adc_sar_pkg::*;
#(
  parameter int SMP_W       = 6,
  parameter int CNV_W       = 10,
  parameter int RES_BITS    = 10,
  parameter int LOW_BITS    = 8,
  parameter int NORM_SAMPLE = 15,
  parameter int NORM_TOTAL  = 158,
  parameter int FAST_SAMPLE = 8,
  parameter int FAST_TOTAL  = 91
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWr,
  input  logic             cmdStartNow,
  input  logic             cmdEight,
  input  logic             extTrig,
  input  logic             fastMode,
  input  logic             cfgTiming,
  input  logic [SMP_W-1:0] sampleCnt,
  input  logic [CNV_W-1:0] convertCnt,
  input  logic             bitIsLast,
  input  logic             nextIsLast,
  input  logic             pendAck,
  output dpStrobe_t        strobe,
  output logic             busy,
  output logic             sampleEn,
  output logic             compStrobe,
  output logic             donePend
);

  localparam int CNT_W = ((CNV_W > SMP_W) ? CNV_W : SMP_W) + 1;
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
  localparam logic [CNT_W-1:0] NORM_SMP  = CNT_W'(NORM_SAMPLE);
  localparam logic [CNT_W-1:0] FAST_SMP  = CNT_W'(FAST_SAMPLE);
  localparam logic [CNT_W-1:0] NORM_CONV = CNT_W'(NORM_TOTAL - NORM_SAMPLE);
  localparam logic [CNT_W-1:0] FAST_CONV = CNT_W'(FAST_TOTAL - FAST_SAMPLE);
  localparam logic [CNT_W-1:0] DIV_HI    = CNT_W'(RES_BITS);
  localparam logic [CNT_W-1:0] DIV_LO    = CNT_W'(LOW_BITS);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] perLen;
  logic [CNT_W-1:0] lastLen;
  logic             modeEight;

  logic             accept;
  logic             goSample;
  logic             eightNow;
  logic [CNT_W-1:0] sampLenNow;
  logic [CNT_W-1:0] convLen;
  logic [CNT_W-1:0] quot;
  logic [CNT_W-1:0] remd;
  logic [CNT_W-1:0] perNow;
  logic [CNT_W-1:0] lastNow;

  assign busy       = (state == ST_SAMPLE) || (state == ST_CONVERT);
  assign sampleEn   = (state == ST_SAMPLE);
  assign compStrobe = (state == ST_CONVERT) && (cnt == '0);
  assign accept     = cmdWr && !busy;

  // timing profile selection, evaluated at the start of sampling
  always_comb begin
    eightNow = accept ? cmdEight : modeEight;
    if (cfgTiming) begin
      sampLenNow = (sampleCnt == '0) ? ONE : CNT_W'(sampleCnt);
      convLen    = CNT_W'(convertCnt);
    end else if (fastMode) begin
      sampLenNow = FAST_SMP;
      convLen    = FAST_CONV;
    end else begin
      sampLenNow = NORM_SMP;
      convLen    = NORM_CONV;
    end
    quot    = eightNow ? (convLen / DIV_LO) : (convLen / DIV_HI);
    remd    = eightNow ? (convLen % DIV_LO) : (convLen % DIV_HI);
    perNow  = (quot == '0) ? ONE : quot;
    lastNow = perNow + remd;
  end

  always_comb begin
    strobe           = '0;
    strobe.load      = accept;
    goSample         = (accept && cmdStartNow) ||
                       ((state == ST_ARMED) && extTrig && !accept);
    strobe.startBits = (state == ST_SAMPLE) && (cnt == '0);
    strobe.decide    = compStrobe;
    strobe.finish    = compStrobe && bitIsLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      perLen    <= ONE;
      lastLen   <= ONE;
      modeEight <= 1'b0;
      donePend  <= 1'b0;
    end else begin
      if (accept) modeEight <= cmdEight;
      unique case (state)
        ST_IDLE, ST_ARMED: begin
          if (goSample) begin
            state   <= ST_SAMPLE;
            cnt     <= sampLenNow - ONE;
            perLen  <= perNow;
            lastLen <= lastNow;
          end else if (accept) begin
            state <= ST_ARMED;
          end
        end
        ST_SAMPLE: begin
          if (cnt == '0) begin
            state <= ST_CONVERT;
            cnt   <= perLen - ONE;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        ST_CONVERT: begin
          if (cnt == '0) begin
            if (bitIsLast) state <= ST_IDLE;
            else           cnt   <= nextIsLast ? (lastLen - ONE) : (perLen - ONE);
          end else begin
            cnt <= cnt - ONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (strobe.finish)  donePend <= 1'b1;
      else if (pendAck)   donePend <= 1'b0;
    end
  end

  // R2: an immediate command starts sampling on the next cycle
  p_start_now_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && cmdStartNow && !busy |=> busy && sampleEn);

  // R3: without an armed command nothing starts
  p_idle_trig_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) && !cmdWr |=> !busy);

  // R11: completion leaves pending set and busy low
  p_done_pend_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> donePend && !busy);

endmodule

// File: rtl/adc_sar_dp.sv
module adc_sar_dp
  import adc_sar_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int LOW_BITS = 8,
  parameter int CH_W     = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [CH_W-1:0]     cmdChan,
  input  logic                cmdEight,
  input  logic                compIn,
  output logic [CH_W-1:0]     chanSel,
  output logic [RES_BITS-1:0] dacCode,
  output logic [RES_BITS-1:0] result,
  output logic                bitIsLast,
  output logic                nextIsLast
);

  localparam int DROP = RES_BITS - LOW_BITS;
  localparam logic [RES_BITS-1:0] MSB_MASK = RES_BITS'(1) << (RES_BITS - 1);
  localparam logic [RES_BITS-1:0] LO_MASK  = RES_BITS'(1) << DROP;
  localparam logic [RES_BITS-1:0] HI_MASK  = RES_BITS'(1);

  logic                eightMode;
  logic [RES_BITS-1:0] sar;
  logic [RES_BITS-1:0] trialMask;
  logic [RES_BITS-1:0] lowMask;
  logic [RES_BITS-1:0] kept;

  assign lowMask    = eightMode ? LO_MASK : HI_MASK;
  assign bitIsLast  = (trialMask == lowMask);
  assign nextIsLast = ((trialMask >> 1) == lowMask);
  assign kept       = compIn ? (sar | trialMask) : sar;
  assign dacCode    = sar | trialMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanSel   <= '0;
      eightMode <= 1'b0;
      sar       <= '0;
      trialMask <= '0;
      result    <= '0;
    end else begin
      if (strobe.load) begin
        chanSel   <= cmdChan;
        eightMode <= cmdEight;
      end
      if (strobe.startBits) begin
        sar       <= '0;
        trialMask <= MSB_MASK;
      end else if (strobe.decide) begin
        sar       <= kept;
        trialMask <= strobe.finish ? '0 : (trialMask >> 1);
      end
      if (strobe.finish) result <= kept;
    end
  end

  // R9: first trial after sampling is the MSB alone
  p_msb_first_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startBits |=> dacCode == MSB_MASK);

  // R9: a low comparator drops the trial bit
  p_drop_bit_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decide && !compIn |=> (sar & $past(trialMask)) == '0);

  // R4: 8-bit results leave the low bits clear
  p_eight_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish && eightMode |=> result[DROP-1:0] == '0);

endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_sar_pkg::*;
#(
  parameter int CH_W        = 3,
  parameter int RES_BITS    = 10,
  parameter int LOW_BITS    = 8,
  parameter int SMP_W       = 6,
  parameter int CNV_W       = 10,
  parameter int NORM_SAMPLE = 15,
  parameter int NORM_TOTAL  = 158,
  parameter int FAST_SAMPLE = 8,
  parameter int FAST_TOTAL  = 91
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdWr,
  input  logic [CH_W+1:0]     cmdData,
  input  logic                extTrig,
  input  logic                fastMode,
  input  logic                cfgTiming,
  input  logic [SMP_W-1:0]    sampleCnt,
  input  logic [CNV_W-1:0]    convertCnt,
  input  logic                compIn,
  input  logic                intMask,
  input  logic                pendAck,
  output logic [CH_W-1:0]     chanSel,
  output logic                sampleEn,
  output logic [RES_BITS-1:0] dacCode,
  output logic                compStrobe,
  output logic [RES_BITS-1:0] result,
  output logic                busy,
  output logic                donePend,
  output logic                intOut
);

  localparam int START_BIT = CH_W;
  localparam int EIGHT_BIT = CH_W + 1;

  dpStrobe_t strobe;
  logic      bitIsLast;
  logic      nextIsLast;

  adc_sar_ctrl #(
    .SMP_W(SMP_W), .CNV_W(CNV_W), .RES_BITS(RES_BITS), .LOW_BITS(LOW_BITS),
    .NORM_SAMPLE(NORM_SAMPLE), .NORM_TOTAL(NORM_TOTAL),
    .FAST_SAMPLE(FAST_SAMPLE), .FAST_TOTAL(FAST_TOTAL)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdWr      (cmdWr),
    .cmdStartNow(cmdData[START_BIT]),
    .cmdEight   (cmdData[EIGHT_BIT]),
    .extTrig    (extTrig),
    .fastMode   (fastMode),
    .cfgTiming  (cfgTiming),
    .sampleCnt  (sampleCnt),
    .convertCnt (convertCnt),
    .bitIsLast  (bitIsLast),
    .nextIsLast (nextIsLast),
    .pendAck    (pendAck),
    .strobe     (strobe),
    .busy       (busy),
    .sampleEn   (sampleEn),
    .compStrobe (compStrobe),
    .donePend   (donePend)
  );

  adc_sar_dp #(
    .RES_BITS(RES_BITS), .LOW_BITS(LOW_BITS), .CH_W(CH_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdChan   (cmdData[CH_W-1:0]),
    .cmdEight  (cmdData[EIGHT_BIT]),
    .compIn    (compIn),
    .chanSel   (chanSel),
    .dacCode   (dacCode),
    .result    (result),
    .bitIsLast (bitIsLast),
    .nextIsLast(nextIsLast)
  );

  assign intOut = donePend & intMask;

  // R10: writes during a conversion leave the channel untouched
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy && cmdWr |=> $stable(chanSel));

  // R11: pending appears exactly as busy drops
  p_fall_pend_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> donePend);

endmodule

// File: tb/adc_sar_seq_test.sv
module adc_sar_seq_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cmdWr;
  logic [4:0] cmdData;
  logic       extTrig;
  logic       fastMode;
  logic       cfgTiming;
  logic [5:0] sampleCnt;
  logic [9:0] convertCnt;
  logic       compIn;
  logic       intMask;
  logic       pendAck;
  logic [2:0] chanSel;
  logic       sampleEn;
  logic [9:0] dacCode;
  logic       compStrobe;
  logic [9:0] result;
  logic       busy;
  logic       donePend;
  logic       intOut;

  always #2.5 clk = ~clk;

  adc_sar_seq uut (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdData(cmdData), .extTrig(extTrig),
    .fastMode(fastMode), .cfgTiming(cfgTiming), .sampleCnt(sampleCnt),
    .convertCnt(convertCnt), .compIn(compIn), .intMask(intMask), .pendAck(pendAck),
    .chanSel(chanSel), .sampleEn(sampleEn), .dacCode(dacCode), .compStrobe(compStrobe),
    .result(result), .busy(busy), .donePend(donePend), .intOut(intOut)
  );

  // behavioural analog inputs and comparator
  localparam logic [9:0] VIN [8] = '{10'd0, 10'd1023, 10'd512, 10'd683,
                                     10'd300, 10'd1, 10'd1022, 10'd3};
  assign compIn = (VIN[chanSel] >= dacCode);

  typedef struct packed {
    int ch; int eight; int fast; int cfg; int sCnt; int cCnt;
    int expSample; int expTotal; int expFirst; int expGap;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{0, 0, 0, 0,  0,   0, 15, 158, 29, 17},
    '{3, 1, 0, 0,  0,   0, 15, 158, 32, 24},
    '{5, 0, 1, 0,  0,   0,  8,  91, 16, 11},
    '{7, 1, 1, 0,  0,   0,  8,  91, 18, 13},
    '{2, 0, 1, 1, 10,  53, 10,  63, 15,  8},
    '{6, 1, 0, 1, 20, 100, 20, 120, 32, 16},
    '{1, 0, 0, 1,  4,  10,  4,  14,  5,  1}
  };

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int mBusy, mSamp, mStrobes, mFirst, mLast, mGap, mK;
  int mBusy1, mSamp1, mChan1, mChanEnd, mPend;
  logic [9:0] mRes;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // start (write or trigger) at a falling edge, then count cycle by cycle
  task automatic runOne(input logic [4:0] cmd, input bit useTrig,
                        input int injectAt, input logic [4:0] injCmd);
    @(negedge clk);
    if (useTrig) extTrig = 1'b1;
    else begin cmdWr = 1'b1; cmdData = cmd; end
    mBusy = 0; mSamp = 0; mStrobes = 0; mFirst = 0; mLast = 0; mGap = 0; mK = 0;
    mBusy1 = 0; mSamp1 = 0; mChan1 = 0;
    do begin
      @(negedge clk);
      mK++;
      cmdWr = 1'b0;
      extTrig = 1'b0;
      if (mK == 1) begin mBusy1 = busy; mSamp1 = sampleEn; mChan1 = chanSel; end
      if (mK == injectAt) begin cmdWr = 1'b1; cmdData = injCmd; end
      if (busy) mBusy++;
      if (sampleEn) mSamp++;
      if (compStrobe) begin
        if (mStrobes == 0) mFirst = mK; else mGap = mK - mLast;
        mLast = mK;
        mStrobes++;
      end
    end while (busy && mK < 4000);
    mPend = donePend;
    mRes = result;
    mChanEnd = chanSel;
  endtask

  task automatic ackPend();
    @(negedge clk) pendAck = 1'b1;
    @(negedge clk) pendAck = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; cmdWr = 1'b0; cmdData = '0; extTrig = 1'b0; fastMode = 1'b0;
    cfgTiming = 1'b0; sampleCnt = '0; convertCnt = '0; intMask = 1'b0; pendAck = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10", "reset busy", busy, 0);
    chk("R11", "reset donePend", donePend, 0);
    chk("R11", "reset intOut", intOut, 0);
    chk("R9", "reset result", result, 0);
    chk("R5", "reset sampleEn", sampleEn, 0);
    chk("R8", "reset compStrobe", compStrobe, 0);

    // table of profiles, widths and channels
    for (int i = 0; i < NVEC; i++) begin
      string tTag;
      logic [9:0] expRes;
      @(negedge clk);
      fastMode = VECS[i].fast[0];
      cfgTiming = VECS[i].cfg[0];
      sampleCnt = 6'(VECS[i].sCnt);
      convertCnt = 10'(VECS[i].cCnt);
      tTag = VECS[i].cfg != 0 ? "R7" : (VECS[i].fast != 0 ? "R6" : "R5");
      runOne({VECS[i].eight[0], 1'b1, 3'(VECS[i].ch)}, 1'b0, 0, 5'd0);
      chk("R2", "busy one cycle after write", mBusy1, 1);
      chk("R2", "sampleEn one cycle after write", mSamp1, 1);
      chk("R1", "chanSel", mChan1, VECS[i].ch);
      chk(tTag, "sample cycles", mSamp, VECS[i].expSample);
      chk(tTag, "busy cycles", mBusy, VECS[i].expTotal);
      chk("R8", "strobe count", mStrobes, VECS[i].eight != 0 ? 8 : 10);
      chk("R8", "first strobe cycle", mFirst, VECS[i].expFirst);
      chk("R8", "last bit gap", mGap, VECS[i].expGap);
      chk("R8", "last strobe at end of busy", mLast, VECS[i].expTotal);
      expRes = VECS[i].eight != 0 ? (VIN[VECS[i].ch] & 10'h3FC) : VIN[VECS[i].ch];
      chk(VECS[i].eight != 0 ? "R4" : "R9", "result", mRes, expRes);
      chk("R11", "donePend as busy falls", mPend, 1);
      ackPend();
    end

    // R3: stray trigger while idle
    fastMode = 1'b0; cfgTiming = 1'b0;
    @(negedge clk) extTrig = 1'b1;
    @(negedge clk) extTrig = 1'b0;
    chk("R3", "busy after idle trigger", busy, 0);
    @(negedge clk);
    chk("R3", "busy two cycles after idle trigger", busy, 0);

    // R3: armed command waits for the trigger
    @(negedge clk) begin cmdWr = 1'b1; cmdData = 5'b0_0_100; end
    @(negedge clk) cmdWr = 1'b0;
    chk("R3", "busy after armed write", busy, 0);
    chk("R1", "chanSel after armed write", chanSel, 4);
    repeat (5) @(negedge clk);
    chk("R3", "still idle while armed", busy, 0);
    runOne(5'd0, 1'b1, 0, 5'd0);
    chk("R3", "busy one cycle after trigger", mBusy1, 1);
    chk("R3", "busy cycles after trigger", mBusy, 158);
    chk("R9", "triggered result", mRes, 300);
    ackPend();

    // R10: command during conversion is dropped
    runOne(5'b0_1_010, 1'b0, 20, 5'b1_1_111);
    chk("R10", "busy cycles with write mid-conversion", mBusy, 158);
    chk("R10", "chanSel kept", mChanEnd, 2);
    chk("R10", "result of original channel", mRes, 512);
    @(negedge clk);
    chk("R10", "ignored write does not start later", busy, 0);

    // R11: masking and acknowledge
    intMask = 1'b0;
    @(negedge clk);
    chk("R11", "pending held", donePend, 1);
    chk("R11", "intOut masked", intOut, 0);
    intMask = 1'b1;
    @(negedge clk);
    chk("R11", "intOut unmasked", intOut, 1);
    pendAck = 1'b1;
    @(negedge clk);
    pendAck = 1'b0;
    chk("R11", "pending cleared", donePend, 0);
    chk("R11", "intOut cleared", intOut, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule